// File: doc/BRIEF.md
# Serial Channel-Select Register

This block holds the channel choice of an eight-way input multiplexer in front of a converter. While the converter shifts its result out, the multiplexer serial clock runs alongside, and the host sends a short programming word on the serial data line at the same time. Each word starts with an enable bit, followed by a 3-bit channel code, most significant bit first. The new choice takes effect only when the frame closes. At that moment the converter chip select rises, so the multiplexer select input `mux_cs_n` falls.

The serial clock and the select are treated as slow inputs that are already synchronous to the block clock `clk`. The block finds their edges in a single register stage. It outputs the active channel index and a one-cycle pulse each time a new index is loaded. Driving the analog switches is left to other logic.

Top module: `chan_sel_reg`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first commit, `chan_idx` is 0 and `chan_load` is 0.
- R2: While `mux_cs_n` is high, each rising edge of `ser_clk` captures `ser_din`. The first captured bit of a frame is the enable bit. The next three bits form the channel code, most significant bit first.
- R3: A complete frame commits on the falling edge of `mux_cs_n`. `chan_idx` takes the new code on the first `clk` edge that samples `mux_cs_n` low, and it is visible after that edge.
- R4: A frame whose enable bit is 0 leaves `chan_idx` unchanged. This includes a frame with `ser_din` held low throughout.
- R5: Bits captured after the fourth bit of a frame are ignored.
- R6: A frame with fewer than four captured bits at the commit edge leaves `chan_idx` unchanged.
- R7: `chan_load` is high for exactly one cycle, in the same cycle that a committed frame loads `chan_idx`. It also pulses when the loaded code equals the current one.
- R8: `ser_clk` edges while `mux_cs_n` is low capture nothing. Every frame starts counting bits from zero.
- R9: Each of the eight codes 0 to 7 can be loaded into `chan_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Multiplexer serial clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial programming data |
| mux_cs_n | input | 1 | Multiplexer select, the inverse of the converter chip select; high during a frame, falling edge commits |
| chan_idx | output | 3 | Active channel index |
| chan_load | output | 1 | One-cycle pulse when a new index is loaded |

## Verification
A captured bit counts toward the frame one `clk` cycle after the sampled rise of `ser_clk`. The channel index and the load pulse change on the first edge that samples `mux_cs_n` low, so both are due one cycle after the select is driven low. The bench updates its behavioural model on each rising edge, from the same sampled inputs the design sees. It compares both outputs on each falling edge, half a cycle after any change. Directed checks after each frame are made several cycles after the commit edge, and one extra check right after the drop confirms the index is already updated.

// File: rtl/chan_sel_reg.sv
module chan_sel_reg #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_clk,
  input  logic            ser_din,
  input  logic            mux_cs_n,
  output logic [CH_W-1:0] chan_idx,
  output logic            chan_load
);
  localparam int WORD_LEN = CH_W + 1;
  localparam int CNT_W    = $clog2(WORD_LEN + 1);

  logic                sclk_q;
  logic                cs_q;
  logic [WORD_LEN-1:0] word;
  logic [CNT_W-1:0]    cnt;

  wire sclk_rise = ser_clk & ~sclk_q;
  wire commit    = cs_q & ~mux_cs_n;
  wire full      = (cnt == CNT_W'(WORD_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q    <= 1'b1;
      cs_q      <= 1'b0;
      word      <= '0;
      cnt       <= '0;
      chan_idx  <= '0;
      chan_load <= 1'b0;
    end else begin
      sclk_q    <= ser_clk;
      cs_q      <= mux_cs_n;
      chan_load <= 1'b0;
      if (!mux_cs_n)
        cnt <= '0;
      else if (sclk_rise && !full) begin
        word <= {word[WORD_LEN-2:0], ser_din};
        cnt  <= cnt + 1'b1;
      end
      if (commit && full && word[WORD_LEN-1]) begin
        chan_idx  <= word[CH_W-1:0];
        chan_load <= 1'b1;
      end
    end
  end
endmodule

module chan_sel_reg_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mux_cs_n,
  input logic [CH_W-1:0] chan_idx,
  input logic            chan_load
);
  a_r7_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_idx != $past(chan_idx)) |-> chan_load);
  a_r3_load_on_low_select: assert property (@(posedge clk) disable iff (!rst_n)
    chan_load |-> !$past(mux_cs_n));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    chan_load |=> !chan_load);
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mux_cs_n && !$past(mux_cs_n)) |=> $stable(chan_idx));
endmodule

bind chan_sel_reg chan_sel_reg_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mux_cs_n(mux_cs_n),
  .chan_idx(chan_idx), .chan_load(chan_load));

// File: tb/tb_chan_sel_reg.sv
module tb_chan_sel_reg;
  logic clk = 0, rst_n = 0, ser_clk = 1, ser_din = 0, mux_cs_n = 0;
  logic [2:0] chan_idx;
  logic chan_load;
  int checks = 0, failures = 0, loads = 0, cyc = 0;
  bit done = 0;

  chan_sel_reg dut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
                    .mux_cs_n(mux_cs_n), .chan_idx(chan_idx), .chan_load(chan_load));

  always #10 clk = ~clk;

  // behavioural reference model
  int m_chan = 0, m_load = 0, prev_sclk = 1, prev_cs = 0;
  bit bq[$];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_chan = 0; m_load = 0; prev_sclk = 1; prev_cs = 0; bq.delete();
    end else begin
      m_load = 0;
      if (!mux_cs_n && prev_cs == 1 && bq.size() >= 4 && bq[0]) begin
        m_chan = bq[1] * 4 + bq[2] * 2 + bq[3];
        m_load = 1;
      end
      if (!mux_cs_n) bq.delete();
      else if (ser_clk && prev_sclk == 0 && bq.size() < 4) bq.push_back(ser_din);
      prev_sclk = ser_clk; prev_cs = mux_cs_n;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(chan_idx == m_chan, "R3 model chan_idx", chan_idx, m_chan);
    check(chan_load == m_load, "R7 model chan_load", chan_load, m_load);
    if (chan_load) loads++;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int n, input logic [7:0] bits);
    mux_cs_n = 1; wait_n(2);
    for (int i = 0; i < n; i++) begin
      ser_din = bits[7-i]; ser_clk = 0; wait_n(2);
      ser_clk = 1; wait_n(2);
    end
    ser_din = 0;
    mux_cs_n = 0; wait_n(4);
  endtask

  int l0;
  initial begin
    wait_n(3);
    check(chan_idx == 0 && chan_load == 0, "R1 in reset", chan_idx, 0);
    rst_n = 1; wait_n(2);
    check(chan_idx == 0 && chan_load == 0, "R1 after reset", chan_idx, 0);

    l0 = loads; frame(4, 8'b1101_0000);
    check(chan_idx == 5, "R2 code 5", chan_idx, 5);
    check(loads - l0 == 1, "R7 one pulse", loads - l0, 1);

    // R3: updated one cycle after the select drops
    mux_cs_n = 1; wait_n(2);
    for (int i = 0; i < 4; i++) begin
      ser_din = (i == 0 || i == 3); ser_clk = 0; wait_n(2); ser_clk = 1; wait_n(2);
    end
    check(chan_idx == 5, "R3 before commit", chan_idx, 5);
    mux_cs_n = 0; wait_n(1);
    check(chan_idx == 1, "R3 right after drop", chan_idx, 1);
    wait_n(3);

    frame(4, 8'b0110_0000);
    check(chan_idx == 1, "R4 enable low", chan_idx, 1);
    frame(4, 8'b0000_0000);
    check(chan_idx == 1, "R4 din held low", chan_idx, 1);

    frame(7, 8'b1010_1110);
    check(chan_idx == 2, "R5 extra bits", chan_idx, 2);
    frame(3, 8'b1110_0000);
    check(chan_idx == 2, "R6 short frame", chan_idx, 2);

    ser_din = 1;
    for (int i = 0; i < 6; i++) begin ser_clk = 0; wait_n(2); ser_clk = 1; wait_n(2); end
    ser_din = 0;
    check(chan_idx == 2, "R8 idle clocks", chan_idx, 2);
    frame(4, 8'b1011_0000);
    check(chan_idx == 3, "R8 fresh count", chan_idx, 3);

    l0 = loads; frame(4, 8'b1011_0000);
    check(loads - l0 == 1, "R7 same code pulse", loads - l0, 1);

    for (int c = 0; c < 8; c++) begin
      frame(4, {1'b1, 3'(c), 4'b0});
      check(chan_idx == c, "R9 channel sweep", chan_idx, c);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule